// File: doc/BRIEF.md
# Multi-Mode 16-bit PWM Timer

This block is a 16-bit timer/counter with a single output-compare channel. A 4-bit waveform mode selects four things together: the counting shape, where the TOP value comes from, the moment a written compare value becomes active, and the point at which the overflow flag sets. The shape is single-slope, dual-slope or clear-on-match. A separate 2-bit pin-action field chooses what the compare output pin does. In PWM modes it selects non-inverted or inverted output. In non-PWM modes it selects toggle, clear or set.

The counter advances only on cycles where the `tick` clock enable is high. An external prescaler is expected to drive `tick`. Software-side writes arrive as simple write-enable plus data pairs for these registers:

- the mode
- the pin action
- the compare value
- the period value
- the counter itself

A force strobe applies the selected pin action at once in non-PWM modes. The overflow flag and the compare-match flag are both cleared by write-one strobes.

Top module: `pwm_timer16`

## Requirements
- R1: After synchronous reset the counter is 0, the pin is 0, both flags are 0, the mode is 0 (free-running) and the pin action is 0 (pin off).
- R2: The counter and both flags change only on cycles with `tick` high. A counter load through `cnt_we` takes effect whether or not `tick` is high.
- R3: In mode 0 the counter counts up, wraps from 0xFFFF to 0, and sets the overflow flag on the tick at which the count is 0xFFFF.
- R4: In clear-on-match modes (4: TOP from the compare value, 12: TOP from the period value), the tick at which the count equals TOP loads 0. The overflow flag sets only at a count of 0xFFFF.
- R5: In single-slope PWM modes, the counter runs 0..TOP and wraps. TOP is 0x00FF, 0x01FF or 0x03FF in modes 5, 6 and 7, the period value in mode 14, and the compare value in mode 15. The overflow flag sets on the tick at TOP. With pin action 2, the pin clears on a match and sets at the wrap; pin action 3 inverts this.
- R6: In dual-slope modes (1–3 fixed TOP, 8 and 10 period TOP, 9 and 11 compare TOP), the counter counts up to TOP and then down to 0. The overflow flag sets on the tick that leaves 0 going down. With pin action 2, the pin clears on an up-count match and sets on a down-count match.
- R7: A written compare value becomes active at once in modes 0, 4, 12 and 13. In modes 1–3, 10 and 11 it becomes active on the tick at TOP while counting up. In modes 5–9, 14 and 15 it becomes active on the tick that returns the count to 0.
- R8: The compare-match flag sets on any tick whose count equals the active compare value. Each flag is cleared by a one on its clear input; a set in the same cycle wins over the clear.
- R9: In non-PWM modes, a compare match applies the pin action: 1 toggles, 2 clears, 3 sets, 0 leaves the pin state alone.
- R10: A write to the pin action takes effect at the next match or force. While the active pin action is 0 the pin is driven 0, but the internal pin state is kept.
- R11: In non-PWM modes the force strobe applies the pin action on the next clock without setting the match flag. In PWM modes it has no effect.
- R12: Mode 13 is reserved: the counter holds, no flag sets and the pin does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Count enable |
| mode_we | input | 1 | Mode write enable |
| mode_wdata | input | 4 | Waveform mode |
| act_we | input | 1 | Pin-action write enable |
| act_wdata | input | 2 | Pin action code |
| cmp_we | input | 1 | Compare value write enable |
| cmp_wdata | input | 16 | Compare value |
| per_we | input | 1 | Period value write enable |
| per_wdata | input | 16 | Period value |
| cnt_we | input | 1 | Counter load enable |
| cnt_wdata | input | 16 | Counter load value |
| force_cmp | input | 1 | Force-compare strobe |
| ovf_clr | input | 1 | Write-one clear of overflow flag |
| match_clr | input | 1 | Write-one clear of match flag |
| oc_pin | output | 1 | Compare output pin |
| ovf_flag | output | 1 | Overflow flag |
| match_flag | output | 1 | Compare-match flag |
| count | output | 16 | Current counter value |

## Verification
The checks assume the following about the inputs:
- In dual-slope modes TOP is non-zero.
- The counter is never loaded above TOP in a mode that wraps at TOP, so the turn and wrap points are actually reached.

The stimulus keeps within these limits by doing all configuration with `tick` held low. It writes the compare value while an immediate-update mode is selected, before entering a buffered mode. It picks TOP values of at least 4.

// File: rtl/pwmt_pkg.sv
package pwmt_pkg;
  typedef enum logic [2:0] {SH_UP, SH_CTC, SH_FAST, SH_DUAL, SH_HOLD} shape_e;
  typedef enum logic [2:0] {TS_MAX, TS_FIX8, TS_FIX9, TS_FIX10, TS_CMP, TS_PER} topsrc_e;
  typedef enum logic [1:0] {UP_NOW, UP_TOP, UP_BOT} upd_e;
  typedef enum logic [1:0] {OV_NONE, OV_MAX, OV_TOP, OV_BOT} ovf_e;

  typedef struct packed {
    shape_e  shape;
    topsrc_e tsrc;
    upd_e    upd;
    ovf_e    ovf;
    logic    pwm;
  } mode_cfg_t;

  localparam logic [1:0] ACT_OFF = 2'd0;
  localparam logic [1:0] ACT_TGL = 2'd1;
  localparam logic [1:0] ACT_LO  = 2'd2;
  localparam logic [1:0] ACT_HI  = 2'd3;
endpackage

// File: rtl/pwmt_mode_decode.sv
module pwmt_mode_decode
  import pwmt_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [3:0]   mode,
  input  logic [W-1:0] cmp_act,
  input  logic [W-1:0] per_q,
  output mode_cfg_t    cfg,
  output logic [W-1:0] top
);
  localparam logic [W-1:0] TOP8  = W'(255);
  localparam logic [W-1:0] TOP9  = W'(511);
  localparam logic [W-1:0] TOP10 = W'(1023);

  always_comb begin
    case (mode)
      4'd0:  cfg = '{SH_UP,   TS_MAX,   UP_NOW, OV_MAX,  1'b0};
      4'd1:  cfg = '{SH_DUAL, TS_FIX8,  UP_TOP, OV_BOT,  1'b1};
      4'd2:  cfg = '{SH_DUAL, TS_FIX9,  UP_TOP, OV_BOT,  1'b1};
      4'd3:  cfg = '{SH_DUAL, TS_FIX10, UP_TOP, OV_BOT,  1'b1};
      4'd4:  cfg = '{SH_CTC,  TS_CMP,   UP_NOW, OV_MAX,  1'b0};
      4'd5:  cfg = '{SH_FAST, TS_FIX8,  UP_BOT, OV_TOP,  1'b1};
      4'd6:  cfg = '{SH_FAST, TS_FIX9,  UP_BOT, OV_TOP,  1'b1};
      4'd7:  cfg = '{SH_FAST, TS_FIX10, UP_BOT, OV_TOP,  1'b1};
      4'd8:  cfg = '{SH_DUAL, TS_PER,   UP_BOT, OV_BOT,  1'b1};
      4'd9:  cfg = '{SH_DUAL, TS_CMP,   UP_BOT, OV_BOT,  1'b1};
      4'd10: cfg = '{SH_DUAL, TS_PER,   UP_TOP, OV_BOT,  1'b1};
      4'd11: cfg = '{SH_DUAL, TS_CMP,   UP_TOP, OV_BOT,  1'b1};
      4'd12: cfg = '{SH_CTC,  TS_PER,   UP_NOW, OV_MAX,  1'b0};
      4'd13: cfg = '{SH_HOLD, TS_MAX,   UP_NOW, OV_NONE, 1'b0};
      4'd14: cfg = '{SH_FAST, TS_PER,   UP_BOT, OV_TOP,  1'b1};
      default: cfg = '{SH_FAST, TS_CMP, UP_BOT, OV_TOP,  1'b1};
    endcase
  end

  always_comb begin
    case (cfg.tsrc)
      TS_FIX8:  top = TOP8;
      TS_FIX9:  top = TOP9;
      TS_FIX10: top = TOP10;
      TS_CMP:   top = cmp_act;
      TS_PER:   top = per_q;
      default:  top = '1;
    endcase
  end
endmodule

// File: rtl/pwmt_counter.sv
module pwmt_counter
  import pwmt_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic [W-1:0] top,
  input  mode_cfg_t    cfg,
  output logic [W-1:0] cnt_q,
  output logic         dir_q,
  output logic         live,
  output logic         ovf_evt,
  output logic         upd_evt,
  output logic         wrap_evt
);
  localparam logic [W-1:0] ONE = W'(1);

  logic at_top, at_zero, dual_bot, at_max;

  assign at_top   = (cnt_q == top);
  assign at_zero  = (cnt_q == '0);
  assign at_max   = (cnt_q == '1);
  assign dual_bot = dir_q & at_zero;
  assign live     = tick & ~load & (cfg.shape != SH_HOLD);
  assign wrap_evt = live & (cfg.shape == SH_FAST) & at_top;

  always_comb begin
    case (cfg.ovf)
      OV_MAX:  ovf_evt = live & at_max;
      OV_TOP:  ovf_evt = live & at_top;
      OV_BOT:  ovf_evt = live & dual_bot;
      default: ovf_evt = 1'b0;
    endcase
  end

  always_comb begin
    case (cfg.upd)
      UP_TOP:  upd_evt = live & ~dir_q & at_top;
      UP_BOT:  upd_evt = live & ((cfg.shape == SH_FAST) ? at_top : dual_bot);
      default: upd_evt = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      dir_q <= 1'b0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (live) begin
      case (cfg.shape)
        SH_CTC, SH_FAST: begin
          cnt_q <= at_top ? '0 : cnt_q + ONE;
          dir_q <= 1'b0;
        end
        SH_DUAL: begin
          if (!dir_q) begin
            if (at_top) begin
              dir_q <= 1'b1;
              cnt_q <= cnt_q - ONE;
            end else begin
              cnt_q <= cnt_q + ONE;
            end
          end else begin
            if (at_zero) begin
              dir_q <= 1'b0;
              cnt_q <= cnt_q + ONE;
            end else begin
              cnt_q <= cnt_q - ONE;
            end
          end
        end
        default: begin
          cnt_q <= cnt_q + ONE;
          dir_q <= 1'b0;
        end
      endcase
    end
  end

  // R2: no tick, no load -> counter frozen
  p_tick_gate_r2: assert property (@(posedge clk) disable iff (rst)
    (!tick && !load) |=> $stable(cnt_q));
  // R12: reserved mode keeps counter and direction
  p_hold_r12: assert property (@(posedge clk) disable iff (rst)
    (cfg.shape == SH_HOLD && !load) |=> ($stable(cnt_q) && $stable(dir_q)));
  // R4: clear-on-match returns to zero
  p_ctc_zero_r4: assert property (@(posedge clk) disable iff (rst)
    (live && cfg.shape == SH_CTC && at_top) |=> (cnt_q == '0));
  // R6: dual slope turns down at TOP
  p_dual_turn_r6: assert property (@(posedge clk) disable iff (rst)
    (live && cfg.shape == SH_DUAL && !dir_q && at_top && top != '0) |=> dir_q);
endmodule

// File: rtl/pwmt_compare.sv
module pwmt_compare
  import pwmt_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  mode_cfg_t    cfg,
  input  logic [W-1:0] cnt_q,
  input  logic         dir_q,
  input  logic         live,
  input  logic         upd_evt,
  input  logic         wrap_evt,
  input  logic         cmp_we,
  input  logic [W-1:0] cmp_wdata,
  input  logic         act_we,
  input  logic [1:0]   act_wdata,
  input  logic         force_cmp,
  output logic [W-1:0] cmp_act,
  output logic         match_evt,
  output logic         pin_q
);
  logic [W-1:0] cmp_buf;
  logic [1:0]   act_req, act_cur, act_use;
  logic         oc_q, oc_nx, force_ok, fire, down_phase;

  assign match_evt  = live & (cnt_q == cmp_act);
  assign force_ok   = force_cmp & ~cfg.pwm & (cfg.shape != SH_HOLD);
  assign fire       = match_evt | force_ok;
  assign act_use    = fire ? act_req : act_cur;
  assign down_phase = (cfg.shape == SH_DUAL) & dir_q;

  always_comb begin
    oc_nx = oc_q;
    if (fire) begin
      if (!cfg.pwm) begin
        case (act_req)
          ACT_TGL: oc_nx = ~oc_q;
          ACT_LO:  oc_nx = 1'b0;
          ACT_HI:  oc_nx = 1'b1;
          default: oc_nx = oc_q;
        endcase
      end else begin
        case (act_req)
          ACT_LO:  oc_nx = down_phase;
          ACT_HI:  oc_nx = ~down_phase;
          default: oc_nx = oc_q;
        endcase
      end
    end
    if (wrap_evt) begin
      case (act_use)
        ACT_LO:  oc_nx = 1'b1;
        ACT_HI:  oc_nx = 1'b0;
        default: oc_nx = oc_nx;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_buf <= '0;
      cmp_act <= '0;
    end else begin
      if (cmp_we) cmp_buf <= cmp_wdata;
      if (cfg.upd == UP_NOW)
        cmp_act <= cmp_we ? cmp_wdata : cmp_buf;
      else if (upd_evt)
        cmp_act <= cmp_buf;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_req <= ACT_OFF;
      act_cur <= ACT_OFF;
      oc_q    <= 1'b0;
      pin_q   <= 1'b0;
    end else begin
      if (act_we) act_req <= act_wdata;
      act_cur <= act_use;
      oc_q    <= oc_nx;
      pin_q   <= (act_use != ACT_OFF) ? oc_nx : 1'b0;
    end
  end

  // R11: force in PWM modes leaves the pin state alone
  p_pwm_force_r11: assert property (@(posedge clk) disable iff (rst)
    (force_cmp && cfg.pwm && !live) |=> $stable(oc_q));
  // R10: active pin action only changes at a match or force
  p_act_defer_r10: assert property (@(posedge clk) disable iff (rst)
    (!match_evt && !force_ok) |=> $stable(act_cur));
  // R7: buffered modes hold the active compare value between update points
  p_cmp_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (cfg.upd != UP_NOW && !upd_evt) |=> $stable(cmp_act));
endmodule

// File: rtl/pwm_timer16.sv
module pwm_timer16
  import pwmt_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         mode_we,
  input  logic [3:0]   mode_wdata,
  input  logic         act_we,
  input  logic [1:0]   act_wdata,
  input  logic         cmp_we,
  input  logic [W-1:0] cmp_wdata,
  input  logic         per_we,
  input  logic [W-1:0] per_wdata,
  input  logic         cnt_we,
  input  logic [W-1:0] cnt_wdata,
  input  logic         force_cmp,
  input  logic         ovf_clr,
  input  logic         match_clr,
  output logic         oc_pin,
  output logic         ovf_flag,
  output logic         match_flag,
  output logic [W-1:0] count
);
  logic [3:0]   mode_q;
  logic [W-1:0] per_q, cmp_act, top, cnt_q;
  mode_cfg_t    cfg;
  logic         dir_q, live, ovf_evt, upd_evt, wrap_evt, match_evt;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q     <= 4'd0;
      per_q      <= '0;
      ovf_flag   <= 1'b0;
      match_flag <= 1'b0;
    end else begin
      if (mode_we) mode_q <= mode_wdata;
      if (per_we)  per_q  <= per_wdata;
      if (ovf_evt)        ovf_flag <= 1'b1;
      else if (ovf_clr)   ovf_flag <= 1'b0;
      if (match_evt)      match_flag <= 1'b1;
      else if (match_clr) match_flag <= 1'b0;
    end
  end

  pwmt_mode_decode #(.W(W)) u_dec (
    .mode(mode_q), .cmp_act(cmp_act), .per_q(per_q), .cfg(cfg), .top(top)
  );

  pwmt_counter #(.W(W)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick), .load(cnt_we), .load_val(cnt_wdata),
    .top(top), .cfg(cfg), .cnt_q(cnt_q), .dir_q(dir_q), .live(live),
    .ovf_evt(ovf_evt), .upd_evt(upd_evt), .wrap_evt(wrap_evt)
  );

  pwmt_compare #(.W(W)) u_cmp (
    .clk(clk), .rst(rst), .cfg(cfg), .cnt_q(cnt_q), .dir_q(dir_q),
    .live(live), .upd_evt(upd_evt), .wrap_evt(wrap_evt),
    .cmp_we(cmp_we), .cmp_wdata(cmp_wdata), .act_we(act_we),
    .act_wdata(act_wdata), .force_cmp(force_cmp), .cmp_act(cmp_act),
    .match_evt(match_evt), .pin_q(oc_pin)
  );

  assign count = cnt_q;

  // R3: overflow event always leaves the flag set
  p_ovf_set_r3: assert property (@(posedge clk) disable iff (rst)
    ovf_evt |=> ovf_flag);
  // R8: match sets the flag, a lone clear drops it
  p_match_set_r8: assert property (@(posedge clk) disable iff (rst)
    match_evt |=> match_flag);
  p_match_clr_r8: assert property (@(posedge clk) disable iff (rst)
    (match_clr && !match_evt) |=> !match_flag);
  // R2: flags frozen without tick and without clears
  p_flag_gate_r2: assert property (@(posedge clk) disable iff (rst)
    (!tick && !ovf_clr && !match_clr) |=> ($stable(ovf_flag) && $stable(match_flag)));
endmodule

// File: tb/sim_pwm_timer16.sv
`timescale 1ns/1ps
module sim_pwm_timer16;
  logic        clk = 1'b0, rst = 1'b1, tick = 1'b0;
  logic        mode_we = 0, act_we = 0, cmp_we = 0, per_we = 0, cnt_we = 0;
  logic [3:0]  mode_wdata = 0;
  logic [1:0]  act_wdata = 0;
  logic [15:0] cmp_wdata = 0, per_wdata = 0, cnt_wdata = 0;
  logic        force_cmp = 0, ovf_clr = 0, match_clr = 0;
  logic        oc_pin, ovf_flag, match_flag;
  logic [15:0] count;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  typedef struct {int sel; logic [15:0] exp; string tag;} item_t;
  item_t sb[$];

  always #2.5 clk = ~clk;

  pwm_timer16 u0 (
    .clk(clk), .rst(rst), .tick(tick), .mode_we(mode_we), .mode_wdata(mode_wdata),
    .act_we(act_we), .act_wdata(act_wdata), .cmp_we(cmp_we), .cmp_wdata(cmp_wdata),
    .per_we(per_we), .per_wdata(per_wdata), .cnt_we(cnt_we), .cnt_wdata(cnt_wdata),
    .force_cmp(force_cmp), .ovf_clr(ovf_clr), .match_clr(match_clr),
    .oc_pin(oc_pin), .ovf_flag(ovf_flag), .match_flag(match_flag), .count(count)
  );

  // monitor: pops expected items and compares at the falling edge
  always @(negedge clk) begin
    item_t it;
    logic [15:0] got;
    while (sb.size() > 0) begin
      it = sb.pop_front();
      case (it.sel)
        0: got = count;
        1: got = {15'd0, oc_pin};
        2: got = {15'd0, ovf_flag};
        default: got = {15'd0, match_flag};
      endcase
      n_chk++;
      if (got !== it.exp) begin
        n_bad++;
        $display("FAIL %s: sel=%0d actual=%h expected=%h", it.tag, it.sel, got, it.exp);
      end
    end
  end

  task automatic push(input int sel, input logic [15:0] v, input string tag);
    item_t it;
    it.sel = sel; it.exp = v; it.tag = tag;
    sb.push_back(it);
  endtask
  task automatic exp_cnt(input logic [15:0] v, input string tag); push(0, v, tag); endtask
  task automatic exp_pin(input logic v, input string tag); push(1, {15'd0, v}, tag); endtask
  task automatic exp_ovf(input logic v, input string tag); push(2, {15'd0, v}, tag); endtask
  task automatic exp_mf(input logic v, input string tag); push(3, {15'd0, v}, tag); endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask
  task automatic wr_mode(input logic [3:0] m);
    mode_we = 1; mode_wdata = m; step(1); mode_we = 0;
  endtask
  task automatic wr_act(input logic [1:0] a);
    act_we = 1; act_wdata = a; step(1); act_we = 0;
  endtask
  task automatic wr_cmp(input logic [15:0] v);
    cmp_we = 1; cmp_wdata = v; step(1); cmp_we = 0;
  endtask
  task automatic wr_per(input logic [15:0] v);
    per_we = 1; per_wdata = v; step(1); per_we = 0;
  endtask
  task automatic wr_cnt(input logic [15:0] v);
    cnt_we = 1; cnt_wdata = v; step(1); cnt_we = 0;
  endtask
  task automatic clr_flags();
    ovf_clr = 1; match_clr = 1; step(1); ovf_clr = 0; match_clr = 0;
  endtask
  task automatic pulse_force();
    force_cmp = 1; step(1); force_cmp = 0;
  endtask

  initial begin
    step(3);
    rst = 0;
    step(1);
    // R1 reset state
    exp_cnt(16'd0, "R1 count"); exp_pin(0, "R1 pin");
    exp_ovf(0, "R1 ovf"); exp_mf(0, "R1 match");

    // R3 free-running wrap and overflow
    wr_cnt(16'hFFFD);
    exp_cnt(16'hFFFD, "R2 load without tick");
    tick = 1; step(2);
    exp_cnt(16'hFFFF, "R3 count at max"); exp_ovf(0, "R3 ovf before wrap");
    step(1);
    exp_cnt(16'h0000, "R3 wrap"); exp_ovf(1, "R3 ovf at max");
    tick = 0; step(3);
    exp_cnt(16'h0000, "R2 no tick hold");
    ovf_clr = 1; step(1); ovf_clr = 0;
    exp_ovf(0, "R8 ovf write-one clear");

    // R4 / R9 clear-on-match, toggle action (code 1)
    wr_mode(4); wr_cmp(16'd5); wr_act(2'd1); wr_cnt(16'd0);
    tick = 1; step(5);
    exp_cnt(16'd5, "R4 count reaches TOP"); exp_pin(0, "R10 pin off before first match");
    step(1);
    exp_cnt(16'd0, "R4 cleared after TOP"); exp_pin(1, "R9 toggle high");
    exp_mf(1, "R8 match flag");
    step(6);
    exp_cnt(16'd0, "R4 period"); exp_pin(0, "R9 toggle low"); exp_ovf(0, "R4 no ovf below max");

    // R11 force in non-PWM mode with set action (code 3)
    tick = 0;
    match_clr = 1; step(1); match_clr = 0;
    exp_mf(0, "R8 match write-one clear");
    wr_act(2'd3); pulse_force();
    exp_pin(1, "R11 force applies set"); exp_mf(0, "R11 force sets no flag");

    // R10 deferred action change to off
    wr_act(2'd0);
    exp_pin(1, "R10 write has no effect before match");
    tick = 1; step(5);
    exp_cnt(16'd5, "R10 action bits leave counting alone"); exp_pin(1, "R10 still old action");
    step(1);
    exp_pin(0, "R10 pin off after match");

    // R5 / R7 fast PWM, TOP from period value, non-inverted (code 2)
    tick = 0;
    wr_cmp(16'd3); wr_mode(14); wr_per(16'd9); wr_act(2'd2); wr_cnt(16'd0); clr_flags();
    tick = 1; step(3);
    exp_cnt(16'd3, "R5 count up");
    step(1);
    exp_pin(0, "R5 clear on match"); exp_mf(1, "R8 match in fast pwm");
    step(5);
    exp_cnt(16'd9, "R5 at TOP"); exp_ovf(0, "R5 no ovf before TOP");
    step(1);
    exp_cnt(16'd0, "R5 wrap"); exp_pin(1, "R5 set at wrap"); exp_ovf(1, "R5 ovf at TOP");
    wr_cmp(16'd6);
    step(3);
    exp_cnt(16'd4, "R7 count"); exp_pin(0, "R7 old compare until bottom");
    step(6);
    exp_cnt(16'd0, "R7 wrap"); exp_pin(1, "R5 set again");
    step(6);
    exp_pin(1, "R7 new compare not yet hit");
    step(1);
    exp_pin(0, "R7 new compare active after bottom");

    // R6 / R7 dual slope, TOP from period value
    tick = 0;
    wr_mode(0); wr_cmp(16'd2); wr_mode(10); wr_per(16'd4); wr_cnt(16'd0); clr_flags();
    tick = 1; step(3);
    exp_cnt(16'd3, "R6 up count"); exp_pin(0, "R6 clear on up match");
    step(2);
    exp_cnt(16'd3, "R6 turned at TOP");
    step(2);
    exp_cnt(16'd1, "R6 down count"); exp_pin(1, "R6 set on down match");
    step(1);
    exp_cnt(16'd0, "R6 bottom"); exp_ovf(0, "R6 no ovf yet");
    step(1);
    exp_cnt(16'd1, "R6 turned at bottom"); exp_ovf(1, "R6 ovf at bottom");
    step(2);
    exp_cnt(16'd3, "R6 second up"); exp_pin(0, "R6 clear again");
    wr_cmp(16'd3);
    exp_cnt(16'd4, "R7 count at TOP");
    step(1);
    exp_cnt(16'd3, "R7 turned"); exp_pin(0, "R7 no match yet");
    step(1);
    exp_cnt(16'd2, "R7 after"); exp_pin(1, "R7 compare updated at TOP");

    // R11 force ignored in PWM mode
    tick = 0;
    match_clr = 1; step(1); match_clr = 0;
    pulse_force();
    exp_pin(1, "R11 force no effect in pwm"); exp_mf(0, "R11 no flag in pwm");

    // R12 reserved mode holds
    wr_mode(13); clr_flags();
    tick = 1; step(5);
    exp_cnt(16'd2, "R12 counter held"); exp_ovf(0, "R12 no ovf");
    exp_mf(0, "R12 no match flag"); exp_pin(1, "R12 pin unchanged");

    tick = 0;
    step(2);
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule